// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds, for a small group of CPUs, two per-CPU pending vectors: one for inter-processor interrupts (IPIs) and one for periodic timer interrupts. Each pending bit drives a level interrupt line toward its CPU. Software reaches the block through a 64-bit register port with a 2-bit register index. A combined control register lets a single write raise IPIs, drop IPIs and drop timer interrupts at once, each through its own 4-bit field. Three narrower registers offer the same operations one at a time. A tick input marks a timer interrupt pending on every active CPU.

Requests and clears that would change nothing are not applied. Instead they raise a one-cycle warning flag. Writes that carry no operation raise a one-cycle error flag. A read returns the pending vectors and, for the control register, the identifier of the CPU that is reading. The parameter `N_CPU` sets the number of lines. The parameter `ACTIVE_CPUS` limits which CPUs respond.

Top module: `ipi_tmr_intc`

## Requirements
- R1: After reset, both pending vectors are zero, all interrupt lines are low, and both flags are low.
- R2: A write to index 0 (the control register) takes an IPI request mask from bits 15:12, an IPI clear mask from bits 11:8 and a timer clear mask from bits 7:4. Bit n of each field addresses CPU n. The request is applied before the clear, so requesting and clearing the same CPU in one write leaves its IPI clear with no warning. A timer clear of a CPU with nothing pending is silent.
- R3: An IPI request for an active CPU that already has an IPI pending raises the warning flag and leaves that bit set. Otherwise the bit is set and the CPU's IPI line rises.
- R4: An IPI clear for an active CPU with no IPI pending, after the request of the same write, raises the warning flag. Otherwise the bit is cleared and the line falls.
- R5: A tick sets the timer pending bit of every active CPU. When a tick and a timer clear of the same CPU arrive in the same cycle, the bit stays set.
- R6: A control write whose three fields are all zero raises the error flag, unless bit 28 (the non-existent-memory acknowledge) is set, in which case it is accepted silently.
- R7: The other registers use bits 3:0 of the written data. A write to index 1 requests IPIs, a write to index 2 clears IPIs, and a write to index 3 clears timer interrupts. If bits 3:0 are zero, the write raises the error flag and changes nothing.
- R8: A read of index 0 returns the reading CPU's identifier in bits 1:0, the timer vector in bits 7:4 and the IPI vector in bits 11:8. A read of index 2 returns the IPI vector in its low bits, and a read of index 3 returns the timer vector. A read of index 1 returns zero, and all other bits read as zero. The read data is valid in the same cycle as the access.
- R9: A CPU with index at or above `ACTIVE_CPUS` is never set, never cleared and never warns. Its request and clear bits are ignored.
- R10: Both flags are registered pulses that are high only in the cycle after the write that caused them. Reads and idle cycles raise no flag and leave the IPI vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 2 | Register index (0 control, 1 IPI request, 2 IPI pending, 3 timer pending) |
| acc_wdata | input | 64 | Write data |
| acc_cpu | input | 2 | Identifier of the accessing CPU |
| acc_rdata | output | 64 | Read data, combinational, zero when not reading |
| tick | input | 1 | Periodic timer event |
| ipi_irq | output | N_CPU | Per-CPU IPI level lines |
| tmr_irq | output | N_CPU | Per-CPU timer level lines |
| err_flag | output | 1 | Pulse: the previous write carried no operation |
| warn_flag | output | 1 | Pulse: the previous write held a redundant IPI request or clear |

## Verification
The hardest situation to reach is a single control write whose fields overlap on one CPU, combined with a tick in the same cycle. The request-before-clear ordering and the tick-over-clear priority only show up then, and the warning decision depends on the pending state that the write itself produces. Directed writes build exactly these overlaps: a request and a clear of the same CPU, a duplicate request together with a clear of another CPU, and a tick aligned with a full timer clear. Seeded random traffic then mixes small 4-bit masks, with frequent zero fields and occasional acknowledge bits, with random ticks. As a result, pending bits are often already set when new requests arrive, and writes to inactive CPUs occur repeatedly.

// File: rtl/ipitm_pkg.sv
package ipitm_pkg;
   localparam int DATA_W    = 64;
   localparam int FIELD_W   = 4;
   localparam int REQ_LSB   = 12;
   localparam int ICLR_LSB  = 8;
   localparam int TCLR_LSB  = 4;
   localparam int ACK_BIT   = 28;
   localparam int CPUID_W   = 2;

   typedef enum logic [1:0] {
      IDX_CTRL    = 2'd0,
      IDX_IPIREQ  = 2'd1,
      IDX_IPIPEND = 2'd2,
      IDX_TMRPEND = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic [FIELD_W-1:0] ipi_set;
      logic [FIELD_W-1:0] ipi_clr;
      logic [FIELD_W-1:0] tmr_clr;
      logic               bad;
   } cmd_t;
endpackage

// File: rtl/ipitm_decode.sv
module ipitm_decode
   import ipitm_pkg::*;
(
   input  logic              valid,
   input  logic              write,
   input  reg_idx_e          idx,
   input  logic [DATA_W-1:0] wdata,
   output cmd_t              cmd
);
   logic wdata_unused;
   assign wdata_unused = ^{wdata[DATA_W-1:ACK_BIT+1], wdata[ACK_BIT-1:REQ_LSB+FIELD_W]};

   always_comb begin
      cmd = '0;
      if (valid && write) begin
         unique case (idx)
            IDX_CTRL: begin
               cmd.ipi_set = wdata[REQ_LSB  +: FIELD_W];
               cmd.ipi_clr = wdata[ICLR_LSB +: FIELD_W];
               cmd.tmr_clr = wdata[TCLR_LSB +: FIELD_W];
               cmd.bad     = ((cmd.ipi_set | cmd.ipi_clr | cmd.tmr_clr) == '0)
                             && !wdata[ACK_BIT];
            end
            IDX_IPIREQ: begin
               cmd.ipi_set = wdata[FIELD_W-1:0];
               cmd.bad     = (cmd.ipi_set == '0);
            end
            IDX_IPIPEND: begin
               cmd.ipi_clr = wdata[FIELD_W-1:0];
               cmd.bad     = (cmd.ipi_clr == '0);
            end
            IDX_TMRPEND: begin
               cmd.tmr_clr = wdata[FIELD_W-1:0];
               cmd.bad     = (cmd.tmr_clr == '0);
            end
            default: cmd = '0;
         endcase
      end
   end
endmodule

// File: rtl/ipitm_pend_bank.sv
module ipitm_pend_bank #(
   parameter int N           = 4,
   parameter int ACTIVE      = 4,
   parameter bit WARN_ON_CLR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] sw_clr,
   input  logic         hw_set,
   output logic [N-1:0] pend,
   output logic         set_dup,
   output logic         clr_miss
);
   localparam logic [N-1:0] ACT_MASK = N'((64'd1 << ACTIVE) - 64'd1);

   logic [N-1:0] set_m, clr_m, with_set;

   assign set_m    = sw_set & ACT_MASK;
   assign clr_m    = sw_clr & ACT_MASK;
   assign with_set = pend | set_m;
   assign set_dup  = |(set_m & pend);

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      if (gi < ACTIVE) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (with_set[gi] & ~clr_m[gi]) | hw_set;
         end
         assign pend[gi] = q;
      end else begin : g_dead
         assign pend[gi] = 1'b0;
      end
   end

   if (WARN_ON_CLR) begin : g_miss
      assign clr_miss = |(clr_m & ~with_set);
   end else begin : g_nomiss
      assign clr_miss = 1'b0;
   end
endmodule

// File: rtl/ipitm_rdmux.sv
module ipitm_rdmux
   import ipitm_pkg::*;
#(
   parameter int N = 4
) (
   input  logic               rd_en,
   input  reg_idx_e           idx,
   input  logic [CPUID_W-1:0] cpu,
   input  logic [N-1:0]       ipi,
   input  logic [N-1:0]       tmr,
   output logic [DATA_W-1:0]  rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (idx)
            IDX_CTRL: begin
               rdata[CPUID_W-1:0]   = cpu;
               rdata[TCLR_LSB +: N] = tmr;
               rdata[ICLR_LSB +: N] = ipi;
            end
            IDX_IPIPEND: rdata[N-1:0] = ipi;
            IDX_TMRPEND: rdata[N-1:0] = tmr;
            default:     rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ipi_tmr_intc.sv
module ipi_tmr_intc
   import ipitm_pkg::*;
#(
   parameter int N_CPU       = 4,
   parameter int ACTIVE_CPUS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [1:0]       acc_idx,
   input  logic [63:0]      acc_wdata,
   input  logic [1:0]       acc_cpu,
   output logic [63:0]      acc_rdata,
   input  logic             tick,
   output logic [N_CPU-1:0] ipi_irq,
   output logic [N_CPU-1:0] tmr_irq,
   output logic             err_flag,
   output logic             warn_flag
);
   if (N_CPU < 1 || N_CPU > FIELD_W) begin : g_bad_ncpu
      $error("N_CPU must lie between 1 and the field width");
   end
   if (ACTIVE_CPUS < 1 || ACTIVE_CPUS > N_CPU) begin : g_bad_active
      $error("ACTIVE_CPUS must lie between 1 and N_CPU");
   end

   reg_idx_e idx;
   cmd_t     cmd;
   logic     ipi_dup, ipi_miss;
   logic     tmr_unused_dup, tmr_unused_miss;
   logic     cmd_unused;

   assign idx = reg_idx_e'(acc_idx);
   assign cmd_unused = ^{cmd.ipi_set, cmd.ipi_clr, cmd.tmr_clr};

   ipitm_decode u_dec (
      .valid (acc_valid),
      .write (acc_write),
      .idx   (idx),
      .wdata (acc_wdata),
      .cmd   (cmd)
   );

   ipitm_pend_bank #(.N(N_CPU), .ACTIVE(ACTIVE_CPUS), .WARN_ON_CLR(1'b1)) u_ipi (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   (cmd.ipi_set[N_CPU-1:0]),
      .sw_clr   (cmd.ipi_clr[N_CPU-1:0]),
      .hw_set   (1'b0),
      .pend     (ipi_irq),
      .set_dup  (ipi_dup),
      .clr_miss (ipi_miss)
   );

   ipitm_pend_bank #(.N(N_CPU), .ACTIVE(ACTIVE_CPUS), .WARN_ON_CLR(1'b0)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   ('0),
      .sw_clr   (cmd.tmr_clr[N_CPU-1:0]),
      .hw_set   (tick),
      .pend     (tmr_irq),
      .set_dup  (tmr_unused_dup),
      .clr_miss (tmr_unused_miss)
   );

   ipitm_rdmux #(.N(N_CPU)) u_rd (
      .rd_en (acc_valid && !acc_write),
      .idx   (idx),
      .cpu   (acc_cpu),
      .ipi   (ipi_irq),
      .tmr   (tmr_irq),
      .rdata (acc_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag  <= 1'b0;
         warn_flag <= 1'b0;
      end else begin
         err_flag  <= cmd.bad;
         warn_flag <= ipi_dup | ipi_miss;
      end
   end
endmodule

// File: rtl/ipitm_chk.sv
module ipitm_chk #(
   parameter int N_CPU       = 4,
   parameter int ACTIVE_CPUS = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_write,
   input logic [1:0]       acc_idx,
   input logic [63:0]      acc_wdata,
   input logic             tick,
   input logic [N_CPU-1:0] ipi_irq,
   input logic [N_CPU-1:0] tmr_irq,
   input logic             err_flag,
   input logic             warn_flag
);
   localparam logic [N_CPU-1:0] ACT = N_CPU'((64'd1 << ACTIVE_CPUS) - 64'd1);

   logic wr;
   assign wr = acc_valid && acc_write;

   assert_tick_sets_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((tmr_irq & ACT) == ACT));

   assert_empty_ctrl_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc_idx == 2'd0 && acc_wdata[15:4] == 12'd0 && !acc_wdata[28]) |=> err_flag);

   assert_dup_req_warn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc_idx == 2'd1 && |(acc_wdata[N_CPU-1:0] & ipi_irq & ACT)) |=> warn_flag);

   assert_ipi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(ipi_irq));

   assert_no_flag_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (!err_flag && !warn_flag));
endmodule

bind ipi_tmr_intc ipitm_chk #(.N_CPU(N_CPU), .ACTIVE_CPUS(ACTIVE_CPUS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_idx   (acc_idx),
   .acc_wdata (acc_wdata),
   .tick      (tick),
   .ipi_irq   (ipi_irq),
   .tmr_irq   (tmr_irq),
   .err_flag  (err_flag),
   .warn_flag (warn_flag)
);

// File: tb/test_ipi_tmr_intc.sv
module test_ipi_tmr_intc;
   localparam int CLK_PERIOD = 10;
   localparam int NC  = 4;
   localparam int ACT = 3;
   localparam logic [3:0] AMASK = 4'b0111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0, tick = 1'b0;
   logic [1:0]  acc_idx = '0, acc_cpu = '0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic [NC-1:0] ipi_irq, tmr_irq;
   logic        err_flag, warn_flag;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [3:0] m_ipi = '0, m_tmr = '0;
   logic       m_err = 0, m_warn = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipi_tmr_intc #(.N_CPU(NC), .ACTIVE_CPUS(ACT)) i_ipi_tmr_intc (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu),
      .acc_rdata(acc_rdata), .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
      .err_flag(err_flag), .warn_flag(warn_flag));

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_read(input logic [1:0] idx, input logic [1:0] cpu);
      logic [63:0] r = '0;
      case (idx)
         2'd0: begin r[1:0] = cpu; r[7:4] = m_tmr; r[11:8] = m_ipi; end
         2'd2: r[3:0] = m_ipi;
         2'd3: r[3:0] = m_tmr;
         default: r = '0;
      endcase
      return r;
   endfunction

   // Reference behaviour from R2..R9
   task automatic model(input logic w, input logic [1:0] idx,
                        input logic [63:0] d, input logic tk);
      logic [3:0] rq = '0, cl = '0, tc = '0, mid;
      logic e = 0;
      if (w) begin
         case (idx)
            2'd0: begin rq = d[15:12]; cl = d[11:8]; tc = d[7:4];
                        e = (d[15:4] == 12'd0) && !d[28]; end
            2'd1: begin rq = d[3:0]; e = (rq == 0); end
            2'd2: begin cl = d[3:0]; e = (cl == 0); end
            default: begin tc = d[3:0]; e = (tc == 0); end
         endcase
      end
      rq &= AMASK; cl &= AMASK; tc &= AMASK;
      m_warn = |(rq & m_ipi);
      mid = m_ipi | rq;
      m_warn |= |(cl & ~mid);
      m_ipi = mid & ~cl;
      m_tmr = (m_tmr & ~tc) | (tk ? AMASK : 4'b0);
      m_err = e;
   endtask

   // Called at a negative edge; returns at the next negative edge.
   task automatic op(input string req, input logic v, input logic w,
                     input logic [1:0] idx, input logic [63:0] d,
                     input logic [1:0] cpu, input logic tk);
      acc_valid = v; acc_write = w; acc_idx = idx; acc_wdata = d;
      acc_cpu = cpu; tick = tk;
      #1;
      if (v && !w) check(req, "rdata", acc_rdata, exp_read(idx, cpu));
      else         check(req, "rdata idle", acc_rdata, 64'd0);
      model(v && w, idx, d, tk);
      @(posedge clk);
      @(negedge clk);
      acc_valid = 0; acc_write = 0; tick = 0;
      check(req, "ipi_irq", 64'(ipi_irq), 64'(m_ipi));
      check(req, "tmr_irq", 64'(tmr_irq), 64'(m_tmr));
      check(req, "err_flag", 64'(err_flag), 64'(m_err));
      check(req, "warn_flag", 64'(warn_flag), 64'(m_warn));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd7411);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1", "ipi", 64'(ipi_irq), 0);
      check("R1", "tmr", 64'(tmr_irq), 0);
      check("R1", "err", 64'(err_flag), 0);
      check("R1", "warn", 64'(warn_flag), 0);

      op("R2", 1, 1, 2'd0, 64'h3000, 0, 0);            // request cpu0,1
      op("R3", 1, 1, 2'd0, 64'h1200, 0, 0);            // dup cpu0, clear cpu1
      op("R2", 1, 1, 2'd0, 64'h4400, 0, 0);            // request+clear cpu2
      op("R4", 1, 1, 2'd2, 64'h4, 0, 0);               // clear cpu2 not pending
      op("R6", 1, 1, 2'd0, 64'h0, 0, 0);               // empty control
      op("R6", 1, 1, 2'd0, 64'h1000_0000, 0, 0);       // acknowledge only
      op("R5", 0, 0, 2'd0, 64'h0, 0, 1);               // tick
      op("R5", 1, 1, 2'd3, 64'h7, 0, 1);               // tick beats clear
      op("R7", 1, 1, 2'd3, 64'hFFFF_0000_0000_0002, 0, 0);
      op("R2", 1, 1, 2'd0, 64'h0010, 0, 0);            // silent timer clear
      op("R9", 1, 1, 2'd1, 64'h8, 0, 0);               // inactive cpu3
      op("R9", 1, 1, 2'd0, 64'h8800, 0, 0);
      op("R7", 1, 1, 2'd2, 64'hF0, 0, 0);              // zero low bits
      op("R7", 1, 1, 2'd1, 64'h6, 0, 0);
      op("R8", 1, 0, 2'd0, 64'h0, 2'd2, 0);
      op("R8", 1, 0, 2'd1, 64'h0, 2'd1, 0);
      op("R8", 1, 0, 2'd2, 64'h0, 2'd3, 0);
      op("R8", 1, 0, 2'd3, 64'h0, 2'd0, 0);
      op("R10", 0, 0, 2'd0, 64'h0, 0, 0);

      for (int n = 0; n < 2000; n++) begin
         int kind = $urandom_range(0, 9);
         logic tk = ($urandom_range(0, 4) == 0);
         logic [1:0] idx = 2'($urandom_range(0, 3));
         logic [1:0] cpu = 2'($urandom_range(0, 3));
         logic [63:0] d = {$urandom, $urandom};
         if (kind < 6) begin
            if (idx == 2'd0) begin
               d[15:12] = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom);
               d[11:8]  = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom);
               d[7:4]   = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom);
               d[28]    = ($urandom_range(0, 7) == 0);
            end else if ($urandom_range(0, 5) == 0) d[3:0] = 4'd0;
            op("random", 1, 1, idx, d, cpu, tk);
         end else if (kind < 9) op("random", 1, 0, idx, d, cpu, tk);
         else                   op("random", 0, 0, idx, d, cpu, tk);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule